// File: doc/BRIEF.md
# Low-Frequency Status Clock Generator

This block turns two board-level indicator pins from static levels into slow waveforms that a human or a simple downstream circuit can read. It builds a 100 Hz clock (or 50 Hz when the rate-halving input is set) whose high time is set in tenths of the period by a 4-bit duty code. It also builds a 1 Hz blink with equal high and low halves, and a short active-low pulse for single events. Each pin has its own mode code. The code decides which waveform the pin carries and which loading flag, if any, gates it. Comparing the measured loading against its thresholds happens elsewhere. This block receives only the resulting flags.

Every time unit comes from a `tick` enable strobe. The `TICKS_PER_MS` parameter gives the number of ticks in one millisecond. One millisecond is one tenth of the 100 Hz period. Both pins are active-low indicators that rest high. Each waveform generator keeps its own period counter. That counter is cleared while the gating condition is false, so a newly enabled waveform always starts with a complete high phase.

Top module: `lfc_status_clock`

## Requirements
- R1: While reset is asserted, and in the first cycle after release with every mode code at zero and the level input high, both pins read 1.
- R2: With turbo mode code 2'b00, `turbo_pin_n` equals the value `turbo_level_n` had one clock earlier.
- R3: The status clock period is 10·TICKS_PER_MS ticks when `half_rate` is 0, and 20·TICKS_PER_MS ticks when `half_rate` is 1.
- R4: For duty codes 0 to 8, the high time of each period is (code+1)/10 of the period. The high phase comes first in each period.
- R5: Duty codes 9 to 15 hold the clocked pin constantly high.
- R6: Turbo mode 2'b01 clocks continuously. Mode 2'b10 clocks only while `over_high` is 1. Mode 2'b11 clocks only while `under_low` is 1. While the gating flag is 0, the pin stays high.
- R7: When the gating flag of a clocked pin turns on, the first high phase lasts the full programmed high time, counted from that enable.
- R8: Event mode codes 3'b001, 3'b010 and 3'b011 clock the event pin under the same gating rules as turbo codes 2'b01, 2'b10 and 2'b11.
- R9: Event mode codes 3'b100 to 3'b111 put a 1 Hz blink with 50 % duty on the event pin while `over_top` or `under_floor` is 1. At all other times the pin stays high.
- R10: While `blink_force` is 1 and `over_top` or `under_floor` is 1, the event pin carries the 1 Hz blink whatever its mode code. When neither flag is set, the pin follows its mode code.
- R11: With event mode 3'b000, an `event_req` strobe drives the event pin low for PULSE_TICKS tick intervals, the first of which may be partial. A request that arrives while a pulse is running is ignored.
- R12: An `event_req` strobe is dropped when the event pin is not in its pulse mode. No pulse appears later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, TICKS_PER_MS strobes per millisecond |
| half_rate | input | 1 | 1 selects the 50 Hz clock, 0 selects 100 Hz |
| duty_sel | input | 4 | Duty code: 0..8 gives 10 %..90 %, 9..15 gives constant high |
| turbo_mode | input | 2 | Turbo pin mode: 00 level, 01 clock, 10 clock when over, 11 clock when under |
| event_mode | input | 3 | Event pin mode: 000 pulse, 001/010/011 gated clock, 1xx blink on extreme |
| blink_force | input | 1 | Forces the blink on the event pin while an extreme flag is set |
| over_high | input | 1 | Loading is above the upper turbo threshold |
| under_low | input | 1 | Loading is below the lower turbo threshold |
| over_top | input | 1 | Loading is above the highest threshold |
| under_floor | input | 1 | Loading is below the lowest threshold |
| turbo_level_n | input | 1 | Static turbo level used in mode 00 |
| event_req | input | 1 | Single-cycle request for an event pulse |
| turbo_pin_n | output | 1 | Turbo indicator pin level |
| event_pin_n | output | 1 | Event indicator pin level |

## Verification
The bench measures exact high and low run lengths for several duty codes at both rates. An off-by-one in the duty arithmetic, or a period that ignores the rate select, therefore shows up as a wrong cycle count instead of a merely visible toggle. The bench gates the waveform on and at two different tick phases, and requires the first high phase to be full length. A generator that runs freely behind the gate would drop the pin early. The bench strobes a second request during a running pulse, and a request while the pin is in another mode. A design that restarts, stretches or queues pulses would produce an over-long or a stray low. The tests for codes 9 and above and for the blink override catch a design that wraps the duty code or lets the mode code win over the forced blink.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    typedef enum logic [1:0] {
        TRB_LEVEL = 2'b00,
        TRB_CLK   = 2'b01,
        TRB_OVER  = 2'b10,
        TRB_UNDER = 2'b11
    } turbo_mode_e;

    typedef enum logic [2:0] {
        EVT_PULSE = 3'b000,
        EVT_CLK   = 3'b001,
        EVT_OVER  = 3'b010,
        EVT_UNDER = 3'b011
    } event_mode_e;

    typedef struct packed {
        logic turbo_pin;
        logic event_pin;
    } pins_t;

    // Number of 10 % steps spent high for a duty code; codes 9 and up give the full period.
    function automatic logic [3:0] duty_steps(input logic [3:0] code);
        return (code >= 4'd9) ? 4'd10 : code + 4'd1;
    endfunction

endpackage

// File: rtl/lfc_wave.sv
module lfc_wave #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] high,
    output logic             wave
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wave_st_t;

    wave_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= period - CNT_W'(1)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // High phase first; a high time that covers the period gives a flat level.
    assign wave = !en || (st_q.cnt < high) || (high >= period);

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0));

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> (st_q.cnt == $past(st_q.cnt)));

endmodule

// File: rtl/lfc_pulse.sv
module lfc_pulse #(
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic req,
    output logic active
);

    localparam int W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else if (req && (st_q.cnt == '0)) begin
            st_d.cnt = W'(PULSE_TICKS);
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.cnt != '0);

    p_no_retrigger_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && req && active && !tick) |=> (st_q.cnt == $past(st_q.cnt)));

    p_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active);

endmodule

// File: rtl/lfc_status_clock.sv
module lfc_status_clock
    import lfc_pkg::*;
#(
    parameter int TICKS_PER_MS = 20,
    parameter int PULSE_TICKS  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       half_rate,
    input  logic [3:0] duty_sel,
    input  logic [1:0] turbo_mode,
    input  logic [2:0] event_mode,
    input  logic       blink_force,
    input  logic       over_high,
    input  logic       under_low,
    input  logic       over_top,
    input  logic       under_floor,
    input  logic       turbo_level_n,
    input  logic       event_req,
    output logic       turbo_pin_n,
    output logic       event_pin_n
);

    localparam int STEP         = TICKS_PER_MS;
    localparam int PERIOD_FAST  = 10 * STEP;
    localparam int PERIOD_SLOW  = 2 * PERIOD_FAST;
    localparam int BLINK_PERIOD = 1000 * TICKS_PER_MS;
    localparam int CNT_W        = $clog2(BLINK_PERIOD + 1);
    localparam int NW           = 3;   // 0: turbo clock, 1: event clock, 2: event blink

    logic [CNT_W-1:0] clk_period, clk_high, base_high;
    logic [CNT_W-1:0] wper  [NW];
    logic [CNT_W-1:0] whigh [NW];
    logic [NW-1:0]    wen;
    logic [NW-1:0]    wv;
    logic             extreme, blink_sel, pulse_en, pulse_active;
    pins_t            pins_d, pins_q;

    always_comb begin
        base_high  = CNT_W'(duty_steps(duty_sel)) * CNT_W'(STEP);
        clk_high   = half_rate ? (base_high << 1) : base_high;
        clk_period = half_rate ? CNT_W'(PERIOD_SLOW) : CNT_W'(PERIOD_FAST);

        extreme   = over_top || under_floor;
        blink_sel = extreme && (blink_force || event_mode[2]);

        wen[0] = (turbo_mode == TRB_CLK)
              || ((turbo_mode == TRB_OVER)  && over_high)
              || ((turbo_mode == TRB_UNDER) && under_low);
        wen[1] = !blink_sel && !event_mode[2]
              && ((event_mode == EVT_CLK)
               || ((event_mode == EVT_OVER)  && over_high)
               || ((event_mode == EVT_UNDER) && under_low));
        wen[2] = blink_sel;

        pulse_en = !blink_sel && (event_mode == EVT_PULSE);

        wper[0]  = clk_period;
        whigh[0] = clk_high;
        wper[1]  = clk_period;
        whigh[1] = clk_high;
        wper[2]  = CNT_W'(BLINK_PERIOD);
        whigh[2] = CNT_W'(BLINK_PERIOD / 2);
    end

    for (genvar g = 0; g < NW; g++) begin : g_wave
        lfc_wave #(.CNT_W(CNT_W)) u_wave (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .en     (wen[g]),
            .period (wper[g]),
            .high   (whigh[g]),
            .wave   (wv[g])
        );
    end

    lfc_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .en     (pulse_en),
        .req    (event_req),
        .active (pulse_active)
    );

    always_comb begin
        pins_d = pins_q;

        if (turbo_mode == TRB_LEVEL) begin
            pins_d.turbo_pin = turbo_level_n;
        end else if (wen[0]) begin
            pins_d.turbo_pin = wv[0];
        end else begin
            pins_d.turbo_pin = 1'b1;
        end

        if (blink_sel) begin
            pins_d.event_pin = wv[2];
        end else if (event_mode == EVT_PULSE) begin
            pins_d.event_pin = !pulse_active;
        end else if (wen[1]) begin
            pins_d.event_pin = wv[1];
        end else begin
            pins_d.event_pin = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '1;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign turbo_pin_n = pins_q.turbo_pin;
    assign event_pin_n = pins_q.event_pin;

    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (turbo_mode == 2'b00) |=> (turbo_pin_n == $past(turbo_level_n)));

    p_flat_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((duty_sel >= 4'd9) && (turbo_mode == 2'b01)) |=> turbo_pin_n);

    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((turbo_mode == 2'b10) && !over_high) |=> turbo_pin_n);

    p_blink_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (event_mode[2] && !over_top && !under_floor) |=> event_pin_n);

endmodule

// File: tb/tb_lfc_status_clock.sv
module tb_lfc_status_clock;

    localparam int TPM = 2;   // ticks per ms in the bench
    localparam int PT  = 3;   // pulse length in ticks

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, tick, half_rate, blink_force;
    logic [3:0] duty_sel;
    logic [1:0] turbo_mode;
    logic [2:0] event_mode;
    logic       over_high, under_low, over_top, under_floor;
    logic       turbo_level_n, event_req;
    logic       turbo_pin_n, event_pin_n;

    lfc_status_clock #(.TICKS_PER_MS(TPM), .PULSE_TICKS(PT)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .half_rate(half_rate),
        .duty_sel(duty_sel), .turbo_mode(turbo_mode), .event_mode(event_mode),
        .blink_force(blink_force), .over_high(over_high), .under_low(under_low),
        .over_top(over_top), .under_floor(under_floor),
        .turbo_level_n(turbo_level_n), .event_req(event_req),
        .turbo_pin_n(turbo_pin_n), .event_pin_n(event_pin_n)
    );

    int checks = 0;
    int fails  = 0;

    // Tick on every other clock: one tick = 2 cycles, one 10 % step = 4 cycles.
    initial begin
        tick = 1'b0;
        forever @(negedge clk) tick = ~tick;
    end

    typedef struct packed {
        logic        half;
        logic [3:0]  duty;
        int          hi;
        int          lo;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 4'd0, 4,  36},
        '{1'b0, 4'd4, 20, 20},
        '{1'b0, 4'd8, 36, 4},
        '{1'b1, 4'd0, 8,  72},
        '{1'b1, 4'd3, 32, 48},
        '{1'b1, 4'd6, 56, 24},
        '{1'b0, 4'd2, 12, 28}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pin(input bit evt);
        return evt ? event_pin_n : turbo_pin_n;
    endfunction

    task automatic measure(input bit evt, output int hi, output int lo);
        logic prev, cur;
        bit   found;
        hi = -1; lo = -1; found = 1'b0;
        prev = pin(evt);
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            cur = pin(evt);
            if (prev && !cur) begin found = 1'b1; break; end
            prev = cur;
        end
        if (!found) return;
        lo = 1;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if (!pin(evt)) lo++; else break;
        end
        hi = 1;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if (pin(evt)) hi++; else break;
        end
    endtask

    task automatic count_low(input bit evt, input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!pin(evt)) lows++;
        end
    endtask

    task automatic first_high(input bit evt, output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (pin(evt)) n++; else break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int hi, lo, n;
        rst_n = 1'b0; half_rate = 1'b0; duty_sel = 4'd4; turbo_mode = 2'b00;
        event_mode = 3'b000; blink_force = 1'b0; over_high = 1'b0; under_low = 1'b0;
        over_top = 1'b0; under_floor = 1'b0; turbo_level_n = 1'b1; event_req = 1'b0;

        // R1: reset state
        repeat (5) @(negedge clk);
        chk(turbo_pin_n && event_pin_n, "R1 pins in reset", {turbo_pin_n, event_pin_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(turbo_pin_n && event_pin_n, "R1 pins after reset", {turbo_pin_n, event_pin_n}, 3);

        // R2: level mode follows the static input one clock later
        turbo_level_n = 1'b0;
        @(negedge clk);
        chk(turbo_pin_n == 1'b0, "R2 level low", turbo_pin_n, 0);
        turbo_level_n = 1'b1;
        @(negedge clk);
        chk(turbo_pin_n == 1'b1, "R2 level high", turbo_pin_n, 1);

        // R3 R4 R8: duty and period table, both pins clocked continuously
        turbo_mode = 2'b01;
        event_mode = 3'b001;
        for (int v = 0; v < 7; v++) begin
            half_rate = VECS[v].half;
            duty_sel  = VECS[v].duty;
            repeat (200) @(negedge clk);
            measure(1'b0, hi, lo);
            chk(hi == VECS[v].hi, "R4 turbo high time", hi, VECS[v].hi);
            chk(lo == VECS[v].lo, "R3 turbo low time", lo, VECS[v].lo);
            measure(1'b1, hi, lo);
            chk(hi == VECS[v].hi && lo == VECS[v].lo, "R8 event clock", hi * 1000 + lo,
                VECS[v].hi * 1000 + VECS[v].lo);
        end

        // R5: codes 9 and above stay flat high
        half_rate = 1'b0;
        duty_sel = 4'd9;
        repeat (100) @(negedge clk);
        count_low(1'b0, 200, n);
        chk(n == 0, "R5 code 9 flat", n, 0);
        duty_sel = 4'd13;
        repeat (100) @(negedge clk);
        count_low(1'b0, 200, n);
        chk(n == 0, "R5 code 13 flat", n, 0);

        // R6: gated turbo modes
        duty_sel = 4'd4;
        turbo_mode = 2'b10;
        over_high = 1'b0;
        repeat (4) @(negedge clk);
        count_low(1'b0, 200, n);
        chk(n == 0, "R6 over gate off", n, 0);
        over_high = 1'b1;
        measure(1'b0, hi, lo);
        chk(hi == 20 && lo == 20, "R6 over gate on", hi * 1000 + lo, 20020);
        turbo_mode = 2'b11;
        under_low = 1'b0;
        repeat (4) @(negedge clk);
        count_low(1'b0, 200, n);
        chk(n == 0, "R6 under gate off", n, 0);
        under_low = 1'b1;
        measure(1'b0, hi, lo);
        chk(hi == 20 && lo == 20, "R6 under gate on", hi * 1000 + lo, 20020);
        under_low = 1'b0;

        // R7: restart on enable at two tick phases (full high = 10 ticks = 19..20 samples)
        turbo_mode = 2'b10;
        for (int k = 0; k < 2; k++) begin
            over_high = 1'b0;
            repeat (50 + k) @(negedge clk);
            over_high = 1'b1;
            first_high(1'b0, n);
            chk(n >= 19 && n <= 20, "R7 first high phase", n, 20);
        end
        over_high = 1'b0;

        // R9: blink mode on extreme flags
        event_mode = 3'b100;
        over_top = 1'b1;
        measure(1'b1, hi, lo);
        chk(hi == 2000 && lo == 2000, "R9 blink over top", hi * 10000 + lo, 20002000);
        over_top = 1'b0;
        repeat (2) @(negedge clk);
        count_low(1'b1, 300, n);
        chk(n == 0, "R9 blink rests high", n, 0);
        event_mode = 3'b111;
        under_floor = 1'b1;
        measure(1'b1, hi, lo);
        chk(hi == 2000 && lo == 2000, "R9 blink under floor", hi * 10000 + lo, 20002000);
        under_floor = 1'b0;

        // R10: forced blink overrides the mode code
        event_mode = 3'b001;
        blink_force = 1'b1;
        over_top = 1'b1;
        measure(1'b1, hi, lo);
        chk(hi == 2000 && lo == 2000, "R10 forced blink", hi * 10000 + lo, 20002000);
        over_top = 1'b0;
        measure(1'b1, hi, lo);
        chk(hi == 20 && lo == 20, "R10 follows mode", hi * 1000 + lo, 20020);
        blink_force = 1'b0;

        // R11: event pulse, second request during the pulse ignored
        event_mode = 3'b000;
        repeat (10) @(negedge clk);
        event_req = 1'b1;
        @(negedge clk);
        event_req = 1'b0;
        count_low(1'b1, 40, n);
        chk(n >= 2 * PT - 1 && n <= 2 * PT, "R11 pulse width", n, 2 * PT);
        event_req = 1'b1;
        @(negedge clk);
        event_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        event_req = 1'b1;
        @(negedge clk);
        event_req = 1'b0;
        count_low(1'b1, 40, n);
        // 3 samples already taken above; the pin went low one cycle after the first strobe
        chk(n >= 2 * PT - 4 && n <= 2 * PT - 3, "R11 retrigger ignored", n, 2 * PT - 3);

        // R12: request dropped outside pulse mode
        event_mode = 3'b010;
        over_high = 1'b0;
        repeat (10) @(negedge clk);
        event_req = 1'b1;
        @(negedge clk);
        event_req = 1'b0;
        event_mode = 3'b000;
        count_low(1'b1, 40, n);
        chk(n == 0, "R12 request dropped", n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule